// File: doc/BRIEF.md
# Multiplexed Wake-Up Line Controller

This block watches a bank of wake-up source signals and folds them onto a small set of wake-up lines. For every line, software picks one of three candidate sources (or a tied-low reserved input), picks whether a rising or a falling transition counts as activity, and enables the line. When an enabled line sees its chosen transition, a sticky flag for that line is set. The flags of the enabled lines are ORed into a single wake request for the power sequencer. The lines are meant to stay alive through the deepest stop level, standby and shutdown, so the block runs from an always-on clock with sources already synchronised to it.

Software reaches the block through a simple single-cycle register port. There are three control words (line enables, line polarities, packed source selectors), a read-only status word holding the flags, and a write-one-to-clear word. Reconfiguring a line while it is enabled never produces a spurious flag: detection restarts from the first sample taken under the new selection and polarity.

With the default of 8 lines, candidate k of line n is source n + 8·k, so 24 sources are covered.

Top module: `wkup_line_ctrl`

## Requirements
- R1: After reset the enable, polarity and select words read zero, all flags are clear and `wake_req` is low.
- R2: The 2-bit selector of line n sits at bits [2n+1:2n] of the select word; code 0 picks source n, code 1 picks source n+8, code 2 picks source n+16, code 3 picks a reserved input tied low, and unselected sources never affect line n.
- R3: Polarity bit n = 0 makes line n react to a low-to-high transition of its selected source, 1 to a high-to-low transition; the opposite transition never sets the flag.
- R4: A qualifying transition on an enabled line sets its flag on the clock edge that first samples the new source level; a line whose enable bit is 0 never sets its flag.
- R5: A flag stays set until software writes 1 to its bit in the clear word; 0 bits leave flags untouched, and a transition detected in the same cycle as the clear keeps the flag set.
- R6: Changing a line's polarity or selector while it is enabled sets no flag by itself; detection resumes from the first sample taken under the new setting.
- R7: `wake_req` is high exactly when some line has both its flag and its enable bit set, with no cycle of delay from the flag or enable registers; disabling a line masks its flag from `wake_req` without clearing it.
- R8: Register addresses: 0 enable (bits 7:0), 1 polarity (bits 7:0), 2 select (bits 15:0), 3 status (read-only, flags in bits 7:0, writes ignored), 4 clear (write-only, reads zero); any other address reads zero and writes to it are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Always-on clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| src_in | input | 24 | Wake-up source levels, synchronous to `clk` |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address for read and write |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data, combinational from `reg_addr` |
| wake_req | output | 1 | Combined wake request to the power sequencer |

## Verification
A wrong per-line state shows up in the status word one clock after the source change that should or should not have set a flag, and in `wake_req` in the same cycle as the flag. A stale previous-sample register after a reconfiguration would show as a flag appearing in the cycle right after the control write, with no source activity at all. A wrong selector decode shows as a flag appearing when a neighbouring line's candidate toggles, or not appearing when the selected one does, which the sweep over every line, code and polarity exposes within one or two cycles of each toggle.

// File: rtl/wkup_pkg.sv
package wkup_pkg;

  localparam int ADDR_W = 3;

  localparam logic [ADDR_W-1:0] A_ENABLE = 3'd0;
  localparam logic [ADDR_W-1:0] A_POLAR  = 3'd1;
  localparam logic [ADDR_W-1:0] A_SELECT = 3'd2;
  localparam logic [ADDR_W-1:0] A_STATUS = 3'd3;
  localparam logic [ADDR_W-1:0] A_CLEAR  = 3'd4;

  // Fold polarity into the sample so that a rising edge always means activity.
  function automatic logic polar_adjust(input logic raw, input logic falling);
    return raw ^ falling;
  endfunction

  // Activity is a 0 -> 1 step of the polarity-adjusted sample.
  function automatic logic step_up(input logic now_s, input logic before_s);
    return now_s & ~before_s;
  endfunction

endpackage

// File: rtl/wkup_regs.sv
module wkup_regs
  import wkup_pkg::*;
#(
  parameter int LINES = 8,
  parameter int SEL_W = 2,
  localparam int DATA_W = LINES * SEL_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  input  logic [LINES-1:0]  flags,
  output logic [LINES-1:0]  line_en,
  output logic [LINES-1:0]  line_pol,
  output logic [DATA_W-1:0] line_sel,
  output logic [LINES-1:0]  clr_pulse,
  output logic [DATA_W-1:0] reg_rdata
);

  logic wr_en_w, wr_pol_w, wr_sel_w, wr_clr_w;

  assign wr_en_w  = reg_wr && (reg_addr == A_ENABLE);
  assign wr_pol_w = reg_wr && (reg_addr == A_POLAR);
  assign wr_sel_w = reg_wr && (reg_addr == A_SELECT);
  assign wr_clr_w = reg_wr && (reg_addr == A_CLEAR);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      line_en  <= '0;
      line_pol <= '0;
      line_sel <= '0;
    end else begin
      if (wr_en_w)  line_en  <= reg_wdata[LINES-1:0];
      if (wr_pol_w) line_pol <= reg_wdata[LINES-1:0];
      if (wr_sel_w) line_sel <= reg_wdata;
    end
  end

  assign clr_pulse = wr_clr_w ? reg_wdata[LINES-1:0] : '0;

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      A_ENABLE: reg_rdata[LINES-1:0] = line_en;
      A_POLAR:  reg_rdata[LINES-1:0] = line_pol;
      A_SELECT: reg_rdata            = line_sel;
      A_STATUS: reg_rdata[LINES-1:0] = flags;
      default:  reg_rdata            = '0;
    endcase
  end

  // R8: a write aimed at the status or clear word leaves the control words alone
  a_r8_ctrl_untouched: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && (reg_addr == A_STATUS || reg_addr == A_CLEAR)) |=>
      ($stable(line_en) && $stable(line_pol) && $stable(line_sel)));

endmodule

// File: rtl/wkup_line.sv
module wkup_line
  import wkup_pkg::*;
#(
  parameter int CANDS = 3,
  parameter int SEL_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CANDS-1:0] cands,
  input  logic [SEL_W-1:0] sel,
  input  logic             pol,
  input  logic             en,
  input  logic             clr,
  output logic             flag_q,
  output logic             edge_hit,
  output logic             cfg_dirty
);

  logic             raw_pick;
  logic             adj_now;
  logic             adj_prev;
  logic [SEL_W-1:0] sel_seen;
  logic             pol_seen;

  // Codes at or above CANDS select the reserved, tied-low input.
  always_comb begin
    raw_pick = 1'b0;
    for (int k = 0; k < CANDS; k++) begin
      if (int'(sel) == k) raw_pick = cands[k];
    end
  end

  assign adj_now   = polar_adjust(raw_pick, pol);
  assign cfg_dirty = (sel != sel_seen) || (pol != pol_seen);
  assign edge_hit  = en && !cfg_dirty && step_up(adj_now, adj_prev);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      adj_prev <= 1'b0;
      sel_seen <= '0;
      pol_seen <= 1'b0;
      flag_q   <= 1'b0;
    end else begin
      adj_prev <= adj_now;
      sel_seen <= sel;
      pol_seen <= pol;
      flag_q   <= edge_hit | (flag_q & ~clr);
    end
  end

  // R6: a configuration change alone never raises the flag
  a_r6_no_flag_on_reconfig: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_dirty && !flag_q) |=> !flag_q);

  // R5: the flag holds until a clear arrives
  a_r5_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && !clr) |=> flag_q);

  // R5: a clear without a coincident detection drops the flag
  a_r5_clear_drops: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !edge_hit) |=> !flag_q);

  // R4: a flag only rises while the line was enabled
  a_r4_rise_needs_en: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_q) |-> $past(en));

endmodule

// File: rtl/wkup_line_ctrl.sv
module wkup_line_ctrl
  import wkup_pkg::*;
#(
  parameter int LINES = 8,
  parameter int CANDS = 3,
  parameter int SEL_W = 2,
  localparam int NSRC   = LINES * CANDS,
  localparam int DATA_W = LINES * SEL_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NSRC-1:0]   src_in,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              wake_req
);

  logic [LINES-1:0]  line_en;
  logic [LINES-1:0]  line_pol;
  logic [DATA_W-1:0] line_sel;
  logic [LINES-1:0]  clr_pulse;
  logic [LINES-1:0]  flags;
  logic [LINES-1:0]  edge_hits;
  logic [LINES-1:0]  dirty;

  wkup_regs #(.LINES(LINES), .SEL_W(SEL_W)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .flags     (flags),
    .line_en   (line_en),
    .line_pol  (line_pol),
    .line_sel  (line_sel),
    .clr_pulse (clr_pulse),
    .reg_rdata (reg_rdata)
  );

  for (genvar n = 0; n < LINES; n++) begin : g_line
    logic [CANDS-1:0] cand_w;
    for (genvar k = 0; k < CANDS; k++) begin : g_cand
      assign cand_w[k] = src_in[n + k*LINES];
    end

    wkup_line #(.CANDS(CANDS), .SEL_W(SEL_W)) u_line (
      .clk       (clk),
      .rst_n     (rst_n),
      .cands     (cand_w),
      .sel       (line_sel[n*SEL_W +: SEL_W]),
      .pol       (line_pol[n]),
      .en        (line_en[n]),
      .clr       (clr_pulse[n]),
      .flag_q    (flags[n]),
      .edge_hit  (edge_hits[n]),
      .cfg_dirty (dirty[n])
    );
  end

  assign wake_req = |(flags & line_en);

  // R7: a request after a clock edge needs an enabled flag that survived it
  a_r7_req_source: assert property (@(posedge clk) disable iff (!rst_n)
    (wake_req && !$past(reg_wr)) |-> ($past(|(edge_hits & line_en)) || $past(wake_req)));

  // R1: the control and status state is quiet right after reset release
  a_r1_quiet_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (flags == '0));

endmodule

// File: tb/wkup_line_ctrl_bench.sv
module wkup_line_ctrl_bench;

  localparam int LINES = 8;
  localparam int NSRC  = 24;
  localparam time CYC  = 20ns;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [23:0] src_in = '0;
  logic        reg_wr = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic        wake_req;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #(CYC/2) clk = ~clk;

  wkup_line_ctrl u_wkup_line_ctrl (
    .clk(clk), .rst_n(rst_n), .src_in(src_in), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .wake_req(wake_req)
  );

  task automatic check(input logic [15:0] act, input logic [15:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0; reg_wdata = '0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic drive(input logic [23:0] v);
    @(negedge clk);
    src_in = v;
    @(negedge clk);
  endtask

  task automatic status_is(input logic [7:0] exp, input string tag);
    logic [15:0] d;
    rd(3'd3, d);
    check(d, {8'h00, exp}, tag);
    check({15'd0, wake_req}, {15'd0, |exp}, {tag, " wake"});
  endtask

  initial begin
    #(CYC * 200000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [15:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset values
    rd(3'd0, d); check(d, 16'h0000, "R1 enable");
    rd(3'd1, d); check(d, 16'h0000, "R1 polarity");
    rd(3'd2, d); check(d, 16'h0000, "R1 select");
    status_is(8'h00, "R1 status");

    // R8: register map, read-back and ignored accesses
    wr(3'd2, 16'hE41B);
    rd(3'd2, d); check(d, 16'hE41B, "R8 select readback");
    wr(3'd1, 16'h00A5);
    rd(3'd1, d); check(d, 16'h00A5, "R8 polarity readback");
    wr(3'd3, 16'hFFFF);
    rd(3'd3, d); check(d, 16'h0000, "R8 status write ignored");
    rd(3'd1, d); check(d, 16'h00A5, "R8 status write leaves polarity");
    rd(3'd4, d); check(d, 16'h0000, "R8 clear reads zero");
    wr(3'd5, 16'hFFFF);
    rd(3'd5, d); check(d, 16'h0000, "R8 unmapped reads zero");
    rd(3'd0, d); check(d, 16'h0000, "R8 unmapped write ignored");

    // R2 R3 R4 R5: sweep every line, selector code and polarity
    for (int n = 0; n < LINES; n++) begin
      for (int c = 0; c < 4; c++) begin
        for (int p = 0; p < 2; p++) begin
          logic [23:0] idle;
          int oc;
          idle = (p != 0) ? 24'hFFFFFF : 24'h000000;
          wr(3'd0, 16'h0000);
          drive(idle);
          wr(3'd4, 16'h00FF);
          wr(3'd1, (p != 0) ? 16'h00FF : 16'h0000);
          wr(3'd2, 16'(c) << (2*n));
          wr(3'd0, 16'h0001 << n);
          @(negedge clk);
          status_is(8'h00, $sformatf("R4 idle line%0d code%0d pol%0d", n, c, p));
          oc = (c + 1) % 4;
          if (oc < 3) begin
            drive(idle ^ (24'h1 << (n + 8*oc)));
            status_is(8'h00, $sformatf("R2 unselected line%0d code%0d pol%0d", n, c, p));
            drive(idle);
          end
          if (c < 3) begin
            drive(idle ^ (24'h1 << (n + 8*c)));
            status_is(8'h01 << n, $sformatf("R3 active edge line%0d code%0d pol%0d", n, c, p));
          end else begin
            drive(idle ^ (24'h010101 << n));
            status_is(8'h00, $sformatf("R2 reserved line%0d pol%0d", n, p));
          end
          wr(3'd4, 16'h0001 << n);
          status_is(8'h00, $sformatf("R5 clear line%0d code%0d pol%0d", n, c, p));
        end
      end
    end

    // R3: the opposite transition does not flag
    wr(3'd0, 16'h0000); wr(3'd1, 16'h0000); wr(3'd2, 16'h0000);
    drive(24'h000001);
    wr(3'd4, 16'h00FF);
    wr(3'd0, 16'h0001);
    drive(24'h000000);
    status_is(8'h00, "R3 falling ignored when rising chosen");

    // R4: disabled line never flags
    wr(3'd0, 16'h0000);
    drive(24'h000004);
    drive(24'h000000);
    status_is(8'h00, "R4 disabled line");

    // R6: polarity change while enabled, source held low
    wr(3'd0, 16'h0001);
    wr(3'd1, 16'h0001);
    @(negedge clk);
    status_is(8'h00, "R6 polarity flip no flag");
    drive(24'h000001);
    status_is(8'h00, "R6 rising ignored after flip");
    drive(24'h000000);
    status_is(8'h01, "R6 falling detected after flip");
    wr(3'd4, 16'h0001);

    // R6: selector change while enabled onto a high source
    wr(3'd1, 16'h0000);
    wr(3'd0, 16'h0002);
    drive(24'h000200);
    wr(3'd2, 16'h0004);
    @(negedge clk);
    status_is(8'h00, "R6 select change no flag");
    drive(24'h000000);
    drive(24'h000200);
    status_is(8'h02, "R6 new source detected");

    // R5: sticky and selective clear
    drive(24'h000000);
    drive(24'h000200);
    status_is(8'h02, "R5 flag stays through more activity");
    wr(3'd4, 16'h00FD);
    status_is(8'h02, "R5 zero bit leaves flag");

    // R5: clear coinciding with a detection keeps the flag
    wr(3'd4, 16'h0002);
    drive(24'h000000);
    @(negedge clk);
    src_in = 24'h000200;
    reg_wr = 1'b1; reg_addr = 3'd4; reg_wdata = 16'h0002;
    @(negedge clk);
    reg_wr = 1'b0; reg_wdata = '0;
    status_is(8'h02, "R5 detection beats clear");

    // R7: disabling masks the request but keeps the flag
    wr(3'd0, 16'h0000);
    rd(3'd3, d); check(d, 16'h0002, "R7 flag kept while disabled");
    check({15'd0, wake_req}, 16'h0000, "R7 request masked");
    wr(3'd0, 16'h0002);
    check({15'd0, wake_req}, 16'h0001, "R7 request back on enable");
    wr(3'd4, 16'h0002);
    check({15'd0, wake_req}, 16'h0000, "R7 request drops with clear");

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule